// File: doc/BRIEF.md
# Partitioned Shared Display FIFO

One line-buffer RAM serves three display planes at once. Two programmable boundaries cut the RAM into three contiguous regions, one for each plane (A, B and C). Each region runs as its own circular FIFO with a push port, a pop port, a level count and a sticky underrun flag. A pixel fetch engine fills the regions and the display planes drain them.

A new split is written through a small configuration port. The write is accepted only while at least one of the two display pipes is off and the boundaries are consistent. An accepted split is held as pending. It takes effect at the next vertical-blank pulse of an enabled pipe, and at that moment all three FIFOs are flushed into their new regions. After reset, planes A and B each own half of the RAM and plane C owns nothing.

Top module: `disp_shared_fifo`

## Requirements
- R1: The configuration word carries the first boundary in bits 8:0 and the second in bits 18:9. Both count RAM entries. Plane A owns entries [0, first), plane B owns [first, second) and plane C owns [second, DEPTH). A plane never holds more entries than its region has.
- R2: After reset the split is first = DEPTH/2 and second = DEPTH, no split is pending, every level is 0, and every underrun flag and cfg_err are 0.
- R3: A configuration write made while both pipe_a_en and pipe_b_en are 1 is ignored and sets cfg_err to 1 in the next cycle.
- R4: A write whose second boundary is not above the first, or is above DEPTH, is rejected and sets cfg_err. Any accepted write clears cfg_err in the next cycle.
- R5: An accepted write becomes pending. The pending split becomes active only on the cycle where vblank_a is high with pipe_a_en set, or vblank_b is high with pipe_b_en set. A vblank of a disabled pipe changes nothing. A later accepted write replaces the pending split.
- R6: When a split becomes active, all three FIFOs drop to level 0 in the next cycle. Pushes and pops made in the activation cycle are discarded.
- R7: Each FIFO returns its data in push order, with its pointers wrapping inside its own region. A push made while the level equals the region size is dropped, even if a pop happens in the same cycle.
- R8: A plane with an empty region keeps level 0 and never accepts a push.
- R9: A pop made while the level is 0 sets that plane's sticky underrun flag. Writing 1 to urun_clr clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R10: The level updates in the cycle after a push or pop. While the level is above 0, pop_data shows the oldest entry without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 19 | Split word: [8:0] first boundary, [18:9] second boundary |
| cfg_err | output | 1 | 1 if the most recent configuration write was rejected |
| pipe_a_en | input | 1 | Display pipe A enabled |
| pipe_b_en | input | 1 | Display pipe B enabled |
| vblank_a | input | 1 | Vertical-blank pulse of pipe A |
| vblank_b | input | 1 | Vertical-blank pulse of pipe B |
| push | input | 3 | Push strobe per plane (bit 0 = A, 1 = B, 2 = C) |
| push_data | input | 3*DATA_W | Push data, plane p in slice p |
| pop | input | 3 | Pop strobe per plane |
| pop_data | output | 3*DATA_W | Oldest entry of each plane |
| level | output | 30 | Entry count per plane, 10 bits each |
| urun | output | 3 | Sticky underrun flag per plane |
| urun_clr | input | 3 | Write-one-to-clear for the underrun flags |

## Verification
The bench goes after these corner cases:
- **Exact region capacity.** It fills each region past its size under several splits. A design that drops the first-boundary entry or computes the region size off by one shows a wrong final level.
- **Long streams through one region.** It pushes and pops long streams through a single region so the pointers wrap several times. A pointer that escaped its region would return another plane's data.
- **Configuration writes that must not land.** It makes writes with both pipes on, with reversed boundaries, with an oversized boundary and with a vblank on a disabled pipe. A design that applied any of these would flush FIFOs or change a plane's capacity, which shows at the levels.
- **Activation cycle and underrun flag.** It pushes in the activation cycle, and it pops and clears an underrun flag in the same cycle. A design without flush gating keeps that push. A design that lets the clear win loses the flag.

// File: rtl/dfifo_pkg.sv
// Package: shared types and region arithmetic for the partitioned display FIFO.
// Assumes RAM depth fits the 9-bit first boundary (at most 511 entries).
package dfifo_pkg;
    localparam int NPLANE = 3;
    localparam int LO_W   = 9;
    localparam int HI_W   = 10;
    localparam int CFG_W  = LO_W + HI_W;

    // Split word layout: upper field is the B/C cut, lower field the A/B cut.
    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } split_t;

    // First entry owned by plane p under split s.
    function automatic logic [HI_W-1:0] rgn_base(input split_t s, input int unsigned p);
        case (p)
            0:       return '0;
            1:       return {1'b0, s.lo};
            default: return s.hi;
        endcase
    endfunction

    // One past the last entry owned by plane p under split s.
    function automatic logic [HI_W-1:0] rgn_lim(input split_t s, input int unsigned p,
                                               input logic [HI_W-1:0] depth);
        case (p)
            0:       return {1'b0, s.lo};
            1:       return s.hi;
            default: return depth;
        endcase
    endfunction
endpackage

// File: rtl/dfifo_split_regs.sv
// Split register: validates configuration writes, holds a pending split and
// moves it to the active copy on a vertical blank of an enabled pipe.
// Assumes vblank inputs are single-cycle pulses in the clk domain.
module dfifo_split_regs
    import dfifo_pkg::*;
#(
    parameter int DEPTH = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pipe_a_en,
    input  logic             pipe_b_en,
    input  logic             vblank_a,
    input  logic             vblank_b,
    output split_t           act,
    output split_t           pend,
    output logic             commit,
    output logic             cfg_err
);
    localparam logic [HI_W-1:0] DEF_HI = HI_W'(DEPTH);
    localparam logic [LO_W-1:0] DEF_LO = LO_W'(DEPTH / 2);

    split_t wr_split;
    split_t act_q;
    split_t pend_q;
    logic   pend_v;
    logic   err_q;
    logic   pipes_ok;
    logic   order_ok;
    logic   range_ok;
    logic   accept;

    assign wr_split = split_t'(cfg_wdata);
    assign pipes_ok = !(pipe_a_en && pipe_b_en);
    assign order_ok = {1'b0, wr_split.lo} < wr_split.hi;
    assign range_ok = wr_split.hi <= DEF_HI;
    assign accept   = cfg_wr && pipes_ok && order_ok && range_ok;
    assign commit   = pend_v && ((vblank_a && pipe_a_en) || (vblank_b && pipe_b_en));

    // Active split: loads the pending copy on a qualified vertical blank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '{hi: DEF_HI, lo: DEF_LO};
        end else if (commit) begin
            act_q <= pend_q;
        end
    end

    // Pending split: captures accepted writes, empties on activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '{hi: DEF_HI, lo: DEF_LO};
            pend_v <= 1'b0;
        end else if (accept) begin
            pend_q <= wr_split;
            pend_v <= 1'b1;
        end else if (commit) begin
            pend_v <= 1'b0;
        end
    end

    // Error flag: reflects the outcome of the latest write attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (cfg_wr) begin
            err_q <= !accept;
        end
    end

    assign act     = act_q;
    assign pend    = pend_q;
    assign cfg_err = err_q;

    // R3
    both_pipes_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && pipe_a_en && pipe_b_en) |=> err_q);
    // R4
    act_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, act_q.lo} < act_q.hi) && (act_q.hi <= DEF_HI));
    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (act_q == $past(act_q)));
endmodule

// File: rtl/dfifo_plane_ctrl.sv
// Per-plane circular FIFO control: pointers that wrap inside the plane's
// region, a level counter and a sticky underrun flag.
// Assumes cur_base <= cur_lim and that flush selects the new region start.
module dfifo_plane_ctrl
    import dfifo_pkg::*;
#(
    parameter int RST_BASE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [HI_W-1:0] cur_base,
    input  logic [HI_W-1:0] cur_lim,
    input  logic [HI_W-1:0] new_base,
    input  logic            push,
    input  logic            pop,
    input  logic            urun_clr,
    output logic            wr_en,
    output logic [HI_W-1:0] wr_addr,
    output logic [HI_W-1:0] rd_addr,
    output logic [HI_W-1:0] level,
    output logic            urun
);
    logic [HI_W-1:0] wr_q;
    logic [HI_W-1:0] rd_q;
    logic [HI_W-1:0] lvl_q;
    logic [HI_W-1:0] size;
    logic            urun_q;
    logic            empty;
    logic            full;
    logic            do_push;
    logic            do_pop;
    logic            urun_set;

    // Next pointer, wrapping from the region end back to its start.
    function automatic logic [HI_W-1:0] adv(input logic [HI_W-1:0] ptr,
                                           input logic [HI_W-1:0] base,
                                           input logic [HI_W-1:0] lim);
        logic [HI_W-1:0] inc;
        inc = ptr + HI_W'(1);
        return (inc == lim) ? base : inc;
    endfunction

    assign size     = cur_lim - cur_base;
    assign empty    = (lvl_q == '0);
    assign full     = (lvl_q == size);
    assign do_push  = push && !full && !flush;
    assign do_pop   = pop && !empty && !flush;
    assign urun_set = pop && empty && !flush;

    // Pointers and level: flush re-seats them, otherwise they track traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= HI_W'(RST_BASE);
            rd_q  <= HI_W'(RST_BASE);
            lvl_q <= '0;
        end else if (flush) begin
            wr_q  <= new_base;
            rd_q  <= new_base;
            lvl_q <= '0;
        end else begin
            if (do_push) wr_q <= adv(wr_q, cur_base, cur_lim);
            if (do_pop)  rd_q <= adv(rd_q, cur_base, cur_lim);
            if (do_push && !do_pop)      lvl_q <= lvl_q + HI_W'(1);
            else if (do_pop && !do_push) lvl_q <= lvl_q - HI_W'(1);
        end
    end

    // Underrun flag: set by an empty pop, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urun_q <= 1'b0;
        end else if (urun_set) begin
            urun_q <= 1'b1;
        end else if (urun_clr) begin
            urun_q <= 1'b0;
        end
    end

    assign wr_en   = do_push;
    assign wr_addr = wr_q;
    assign rd_addr = rd_q;
    assign level   = lvl_q;
    assign urun    = urun_q;

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= size);
    // R8
    empty_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == '0) |-> (lvl_q == '0) && !wr_en);
    // R6
    flush_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (lvl_q == '0));
    // R9
    urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_q && !urun_clr) |=> urun_q);
endmodule

// File: rtl/dfifo_shared_ram.sv
// Shared line-buffer RAM: one write and one read port per plane.
// Assumes the write addresses of different ports never coincide (disjoint
// regions); reads are asynchronous so a plane sees its head entry at once.
module dfifo_shared_ram
    import dfifo_pkg::*;
#(
    parameter int DEPTH  = 288,
    parameter int DATA_W = 32,
    parameter int NPORT  = 3
) (
    input  logic                    clk,
    input  logic [NPORT-1:0]        we,
    input  logic [NPORT*HI_W-1:0]   waddr,
    input  logic [NPORT*DATA_W-1:0] wdata,
    input  logic [NPORT*HI_W-1:0]   raddr,
    output logic [NPORT*DATA_W-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [HI_W-1:0] LIM = HI_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: every enabled port writes its own entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPORT; i++) begin
            if (we[i] && (waddr[i*HI_W +: HI_W] < LIM)) begin
                mem[waddr[i*HI_W +: AW]] <= wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        logic [HI_W-1:0] ra;
        assign ra = raddr[p*HI_W +: HI_W];
        assign rdata[p*DATA_W +: DATA_W] = (ra < LIM) ? mem[ra[AW-1:0]] : '0;
    end
endmodule

// File: rtl/disp_shared_fifo.sv
// Partitioned shared display FIFO top: one RAM, three planes, a
// double-buffered split applied at vertical blank with a full flush.
// Assumes DEPTH <= 511 and plane order A, B, C in every packed port.
module disp_shared_fifo
    import dfifo_pkg::*;
#(
    parameter int DEPTH  = 288,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic                     cfg_err,
    input  logic                     pipe_a_en,
    input  logic                     pipe_b_en,
    input  logic                     vblank_a,
    input  logic                     vblank_b,
    input  logic [NPLANE-1:0]        push,
    input  logic [NPLANE*DATA_W-1:0] push_data,
    input  logic [NPLANE-1:0]        pop,
    output logic [NPLANE*DATA_W-1:0] pop_data,
    output logic [NPLANE*HI_W-1:0]   level,
    output logic [NPLANE-1:0]        urun,
    input  logic [NPLANE-1:0]        urun_clr
);
    split_t                   act;
    split_t                   pend;
    logic                     commit;
    logic [NPLANE-1:0]        we;
    logic [NPLANE*HI_W-1:0]   waddr;
    logic [NPLANE*HI_W-1:0]   raddr;

    dfifo_split_regs #(.DEPTH(DEPTH)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .pipe_a_en (pipe_a_en),
        .pipe_b_en (pipe_b_en),
        .vblank_a  (vblank_a),
        .vblank_b  (vblank_b),
        .act       (act),
        .pend      (pend),
        .commit    (commit),
        .cfg_err   (cfg_err)
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        localparam int RB = (p == 0) ? 0 : ((p == 1) ? DEPTH / 2 : DEPTH);
        logic [HI_W-1:0] cb;
        logic [HI_W-1:0] cl;
        logic [HI_W-1:0] nb;

        assign cb = rgn_base(act, p);
        assign cl = rgn_lim(act, p, HI_W'(DEPTH));
        assign nb = rgn_base(pend, p);

        dfifo_plane_ctrl #(.RST_BASE(RB)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (commit),
            .cur_base (cb),
            .cur_lim  (cl),
            .new_base (nb),
            .push     (push[p]),
            .pop      (pop[p]),
            .urun_clr (urun_clr[p]),
            .wr_en    (we[p]),
            .wr_addr  (waddr[p*HI_W +: HI_W]),
            .rd_addr  (raddr[p*HI_W +: HI_W]),
            .level    (level[p*HI_W +: HI_W]),
            .urun     (urun[p])
        );
    end

    dfifo_shared_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NPORT(NPLANE)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (push_data),
        .raddr (raddr),
        .rdata (pop_data)
    );
endmodule

// File: tb/disp_shared_fifo_tb.sv
`timescale 1ns/1ps
module disp_shared_fifo_tb;
    localparam int DEPTH = 288;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [18:0]   cfg_wdata = '0;
    logic          cfg_err;
    logic          pipe_a_en = 1'b1;
    logic          pipe_b_en = 1'b0;
    logic          vblank_a = 1'b0;
    logic          vblank_b = 1'b0;
    logic [2:0]    push = '0;
    logic [3*DW-1:0] push_data = '0;
    logic [2:0]    pop = '0;
    logic [3*DW-1:0] pop_data;
    logic [29:0]   level;
    logic [2:0]    urun;
    logic [2:0]    urun_clr = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    disp_shared_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_err(cfg_err), .pipe_a_en(pipe_a_en), .pipe_b_en(pipe_b_en),
        .vblank_a(vblank_a), .vblank_b(vblank_b), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .level(level), .urun(urun), .urun_clr(urun_clr)
    );

    // Reference model state
    logic [DW-1:0] q0[$];
    logic [DW-1:0] q1[$];
    logic [DW-1:0] q2[$];
    int  m_a = DEPTH / 2, m_b = DEPTH, p_a = 0, p_b = 0;
    bit  p_v = 0, m_err = 0;
    bit  m_ur [3];

    function automatic int qsz(int p);
        case (p) 0: return q0.size(); 1: return q1.size(); default: return q2.size(); endcase
    endfunction
    function automatic logic [DW-1:0] qhead(int p);
        case (p) 0: return q0[0]; 1: return q1[0]; default: return q2[0]; endcase
    endfunction
    function automatic int rsize(int p);
        case (p) 0: return m_a; 1: return m_b - m_a; default: return DEPTH - m_b; endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each rising edge from the inputs then present.
    always @(posedge clk) begin
        if (!rst_n) begin
            q0.delete(); q1.delete(); q2.delete();
            m_a = DEPTH / 2; m_b = DEPTH; p_v = 0; m_err = 0;
            for (int p = 0; p < 3; p++) m_ur[p] = 0;
        end else begin
            bit commit;
            commit = p_v && ((vblank_a && pipe_a_en) || (vblank_b && pipe_b_en));
            for (int p = 0; p < 3; p++) begin
                bit set_ur;
                int sz;
                set_ur = 0;
                sz = qsz(p);
                if (!commit) begin
                    if (pop[p] && sz == 0) set_ur = 1;
                    if (pop[p] && sz > 0) begin
                        case (p) 0: void'(q0.pop_front()); 1: void'(q1.pop_front());
                                 default: void'(q2.pop_front()); endcase
                    end
                    if (push[p] && sz < rsize(p)) begin
                        case (p) 0: q0.push_back(push_data[0 +: DW]);
                                 1: q1.push_back(push_data[DW +: DW]);
                                 default: q2.push_back(push_data[2*DW +: DW]); endcase
                    end
                end
                if (set_ur) m_ur[p] = 1;
                else if (urun_clr[p]) m_ur[p] = 0;
            end
            if (commit) begin
                m_a = p_a; m_b = p_b; p_v = 0;
                q0.delete(); q1.delete(); q2.delete();
            end
            if (cfg_wr) begin
                int fa, fb;
                fa = int'(cfg_wdata[8:0]);
                fb = int'(cfg_wdata[18:9]);
                if (!(pipe_a_en && pipe_b_en) && fb > fa && fb <= DEPTH) begin
                    p_a = fa; p_b = fb; p_v = 1; m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3/R4 cfg_err", int'(cfg_err), int'(m_err));
            for (int p = 0; p < 3; p++) begin
                chk("R7 level", int'(level[p*10 +: 10]), qsz(p));
                chk("R9 urun", int'(urun[p]), int'(m_ur[p]));
                if (qsz(p) > 0)
                    chk("R10 head", int'(pop_data[p*DW +: DW]), int'(qhead(p)));
            end
        end
    end

    task automatic push_n(int p, int n, int seed);
        for (int i = 0; i < n; i++) begin
            push[p] = 1'b1;
            push_data[p*DW +: DW] = DW'(seed + i);
            @(negedge clk);
        end
        push[p] = 1'b0;
    endtask

    task automatic pop_n(int p, int n);
        for (int i = 0; i < n; i++) begin
            pop[p] = 1'b1;
            @(negedge clk);
        end
        pop[p] = 1'b0;
    endtask

    task automatic cfg(int lo, int hi);
        cfg_wdata = {10'(hi), 9'(lo)};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic vb(int which);
        if (which == 0) vblank_a = 1'b1; else vblank_b = 1'b1;
        @(negedge clk);
        vblank_a = 1'b0;
        vblank_b = 1'b0;
    endtask

    function automatic int lvl(int p);
        return int'(level[p*10 +: 10]);
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        for (int p = 0; p < 3; p++) chk("R2 reset level", lvl(p), 0);
        chk("R2 reset urun", int'(urun), 0);
        chk("R2 reset cfg_err", int'(cfg_err), 0);

        // R2 / R1 default split: A holds half, C holds nothing (R8)
        push_n(0, 150, 1000);
        chk("R2 default A capacity", lvl(0), DEPTH / 2);
        push_n(2, 3, 50);
        chk("R8 empty region push", lvl(2), 0);
        pop_n(2, 1);
        chk("R9 underrun on empty C", int'(urun[2]), 1);

        // R10 head visible, R7 order on drain, R9 underrun on A
        chk("R10 head of A", int'(pop_data[0 +: DW]), 1000);
        pop_n(0, DEPTH / 2);
        chk("R7 A drained", lvl(0), 0);
        pop_n(0, 1);
        chk("R9 underrun on A", int'(urun[0]), 1);

        // R9 set wins over clear, then clear alone
        pop[2] = 1'b1; urun_clr[2] = 1'b1;
        @(negedge clk);
        pop[2] = 1'b0; urun_clr[2] = 1'b0;
        chk("R9 set beats clear", int'(urun[2]), 1);
        urun_clr = 3'b111;
        @(negedge clk);
        urun_clr = '0;
        chk("R9 clear", int'(urun), 0);

        // R7 long stream through B wraps its region twice
        for (int i = 0; i < 300; i++) begin
            push[1] = 1'b1;
            push_data[DW +: DW] = DW'(5000 + i);
            pop[1] = (i >= 3);
            @(negedge clk);
        end
        push[1] = 1'b0; pop[1] = 1'b0;
        chk("R7 stream level B", lvl(1), 3);
        chk("R7 stream head B", int'(pop_data[DW +: DW]), 5297);

        // R3 write with both pipes on is ignored
        pipe_b_en = 1'b1;
        cfg(100, 200);
        chk("R3 both pipes err", int'(cfg_err), 1);
        vb(0);
        chk("R3 ignored write no flush", lvl(1), 3);
        pipe_b_en = 1'b0;

        // R4 ordering and range rules
        cfg(100, 100);
        chk("R4 equal bounds err", int'(cfg_err), 1);
        cfg(100, 300);
        chk("R4 oversize err", int'(cfg_err), 1);
        cfg(100, 200);
        chk("R4 accepted clears err", int'(cfg_err), 0);

        // R5 vblank of disabled pipe changes nothing
        vb(1);
        chk("R5 disabled vblank", lvl(1), 3);

        // R6 activation flushes; a push in that cycle is dropped
        push[0] = 1'b1; push_data[0 +: DW] = 32'd77; vblank_a = 1'b1;
        @(negedge clk);
        push[0] = 1'b0; vblank_a = 1'b0;
        chk("R6 flush A", lvl(0), 0);
        chk("R6 flush B", lvl(1), 0);

        // R1 new split 100/200 capacities
        push_n(0, 120, 10);
        chk("R1 A capacity", lvl(0), 100);
        push_n(1, 120, 300);
        chk("R1 B capacity", lvl(1), 100);
        push_n(2, 120, 600);
        chk("R1 C capacity", lvl(2), DEPTH - 200);

        // R5 later accepted write replaces pending
        cfg(0, 50);
        cfg(10, 20);
        vb(0);
        push_n(0, 15, 900);
        chk("R5 replaced pending A", lvl(0), 10);
        push_n(1, 12, 950);
        chk("R5 replaced pending B", lvl(1), 10);

        // R8 empty A region; R7 full region drops push with pop
        cfg(0, DEPTH);
        vb(0);
        push_n(0, 2, 1);
        chk("R8 empty A push", lvl(0), 0);
        pop_n(0, 1);
        chk("R8 pop empty A underrun", int'(urun[0]), 1);
        push_n(1, DEPTH + 2, 20000);
        chk("R7 B full", lvl(1), DEPTH);
        push[1] = 1'b1; pop[1] = 1'b1; push_data[DW +: DW] = 32'd7;
        @(negedge clk);
        push[1] = 1'b0; pop[1] = 1'b0;
        chk("R7 full push dropped", lvl(1), DEPTH - 1);
        pop_n(1, DEPTH - 1);
        chk("R7 B emptied", lvl(1), 0);

        repeat (3) @(negedge clk);
        report();
    end
endmodule